// File: doc/BRIEF.md
# Machine Check and Checkstop Controller

This block gathers machine-check fault sources for a processor core. These sources are internal fault lines, an external active-low fault pin that configuration can mask, and a data-access cache parity error. It records every source it sees in a sticky syndrome register. When the core's state word has its machine-check enable bit set, a detected fault becomes a one-cycle redirect. The redirect carries a handler address, a cleaned-up state word to load, and the interrupted PC and state captured in two save registers.

When the enable bit is clear, a fault does not wait as a pending request. The block drops into checkstop instead and raises a halt output that stays high until reset. A separate request from the watchdog, sent on its second overflow, also forces checkstop. Software reaches the save, syndrome, data-address, prefix and offset registers through a simple select-based read port and write port.

Top module: `mchk_ctrl`

## Requirements
- R1: After reset, `halt_o` and `take_o` are 0 and every register read through the port returns 0.
- R2: A fault seen while `cur_st_i[5]` (machine-check enable) is 1 makes `take_o` high for exactly the following cycle. In that cycle `vec_o` equals {prefix[15:0], offset[11:0], 4'b0000}.
- R3: A fault seen while `cur_st_i[5]` is 0 sets `halt_o` from the next cycle on, with no `take_o`. `halt_o` stays high until reset.
- R4: While halted, faults cause no `take_o` and leave the syndrome unchanged.
- R5: The external pin `mcp_n_i` counts as a fault only when it is low and `ext_en_i` is 1. It records as syndrome bit 8.
- R6: On a take, `new_st_o` equals `cur_st_i` with bits 0–3 and 5–13 cleared and all other bits kept.
- R7: On a take, `new_st_o[4]` (debug enable) is cleared when `dbg_unit_en_i` is 0 or `dbg_clr_i` is 1. Otherwise it keeps `cur_st_i[4]`.
- R8: Syndrome bits [7:0] follow `src_i`, bit 8 the external pin and bit 9 the parity error. They are sticky. Writing ones to select 0 clears them. A bit set in the same cycle as its clear stays set.
- R9: On a take, save register 0 (select 1) holds the `pc_i` value and save register 1 (select 2) holds the `cur_st_i` value from the cycle the fault was seen.
- R10: The data-address register (select 3) takes `par_addr_i` only on a take whose fault includes `par_err_i`. Otherwise it keeps its value.
- R11: `wdog_stop_i` high for one cycle sets `halt_o` on the next cycle, whatever the enable bit holds.
- R12: Select codes are 0 syndrome, 1 save 0, 2 save 1, 3 data address, 4 prefix (low 16 bits) and 5 offset (low 12 bits). Written values read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 8 | Internal fault sources |
| mcp_n_i | input | 1 | External fault pin, active low |
| ext_en_i | input | 1 | Enables the external pin |
| par_err_i | input | 1 | Data-access cache parity error |
| par_addr_i | input | 32 | Effective address of the failing access |
| wdog_stop_i | input | 1 | Checkstop request on second watchdog overflow |
| dbg_unit_en_i | input | 1 | Debug unit enabled |
| dbg_clr_i | input | 1 | Clear debug enable on entry when debug unit is on |
| cur_st_i | input | 32 | Current state word |
| pc_i | input | 32 | PC of the executing instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register write select |
| wr_data_i | input | 32 | Register write data |
| rd_sel_i | input | 3 | Register read select |
| rd_data_o | output | 32 | Register read data |
| take_o | output | 1 | Redirect pulse |
| vec_o | output | 32 | Handler address |
| new_st_o | output | 32 | State word to load on redirect |
| halt_o | output | 1 | Checkstop halt |

## Verification
The bench checks that a fault arriving with the enable bit clear halts the core instead of leaving a pending redirect. A design that queued the fault would later pulse `take_o` once enable returned. It also checks that halt survives further faults and only reset releases it. A design that let sources through while halted would corrupt the syndrome or redirect. On the register side, the bench races a write-one-clear against a new set of the same bit, where a wrong priority loses a fault record. It also checks that the data-address register moves only on parity-caused takes and that the debug-enable rule follows both control inputs.

// File: rtl/mchk_ctrl.sv
module mchk_ctrl #(
  parameter int NSRC  = 8,
  parameter int XLEN  = 32,
  parameter int PFX_W = 16,
  parameter int OFS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            mcp_n_i,
  input  logic            ext_en_i,
  input  logic            par_err_i,
  input  logic [XLEN-1:0] par_addr_i,
  input  logic            wdog_stop_i,
  input  logic            dbg_unit_en_i,
  input  logic            dbg_clr_i,
  input  logic [XLEN-1:0] cur_st_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_sel_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [2:0]      rd_sel_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            take_o,
  output logic [XLEN-1:0] vec_o,
  output logic [XLEN-1:0] new_st_o,
  output logic            halt_o
);
  localparam int SYN_W = NSRC + 2;
  localparam int B_DBG = 4;
  localparam int B_MCEN = 5;
  localparam logic [XLEN-1:0] CLR_MASK = XLEN'(14'h3FEF);
  localparam logic [2:0] SEL_SYN = 3'd0, SEL_SV0 = 3'd1, SEL_SV1 = 3'd2,
                         SEL_DAD = 3'd3, SEL_PFX = 3'd4, SEL_OFS = 3'd5;

  logic [SYN_W-1:0] syn_q;
  logic [XLEN-1:0]  sv0_q, sv1_q, dad_q;
  logic [PFX_W-1:0] pfx_q;
  logic [OFS_W-1:0] ofs_q;
  logic             take_q, halt_q;
  logic [XLEN-1:0]  nst_q;

  wire ext_hit = ext_en_i & ~mcp_n_i;
  wire [SYN_W-1:0] syn_set = halt_q ? '0 : {par_err_i, ext_hit, src_i};
  wire fault   = |syn_set;
  wire take_d  = fault & cur_st_i[B_MCEN];
  wire stop_d  = (fault & ~cur_st_i[B_MCEN]) | wdog_stop_i;
  wire dbg_clr = ~dbg_unit_en_i | dbg_clr_i;
  wire wr_syn  = wr_en_i && wr_sel_i == SEL_SYN;
  wire [SYN_W-1:0] syn_clr = wr_syn ? wr_data_i[SYN_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q  <= '0;
      sv0_q  <= '0;
      sv1_q  <= '0;
      dad_q  <= '0;
      pfx_q  <= '0;
      ofs_q  <= '0;
      take_q <= 1'b0;
      halt_q <= 1'b0;
      nst_q  <= '0;
    end else begin
      syn_q  <= (syn_q & ~syn_clr) | syn_set;
      take_q <= take_d;
      if (stop_d) halt_q <= 1'b1;
      if (wr_en_i && wr_sel_i == SEL_PFX) pfx_q <= wr_data_i[PFX_W-1:0];
      if (wr_en_i && wr_sel_i == SEL_OFS) ofs_q <= wr_data_i[OFS_W-1:0];
      if (take_d) begin
        sv0_q <= pc_i;
        sv1_q <= cur_st_i;
        nst_q <= (cur_st_i & ~CLR_MASK) & ~(XLEN'(dbg_clr) << B_DBG);
      end else begin
        if (wr_en_i && wr_sel_i == SEL_SV0) sv0_q <= wr_data_i;
        if (wr_en_i && wr_sel_i == SEL_SV1) sv1_q <= wr_data_i;
      end
      if (take_d && par_err_i) dad_q <= par_addr_i;
      else if (wr_en_i && wr_sel_i == SEL_DAD) dad_q <= wr_data_i;
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_SYN: rd_data_o = XLEN'(syn_q);
      SEL_SV0: rd_data_o = sv0_q;
      SEL_SV1: rd_data_o = sv1_q;
      SEL_DAD: rd_data_o = dad_q;
      SEL_PFX: rd_data_o = XLEN'(pfx_q);
      SEL_OFS: rd_data_o = XLEN'(ofs_q);
      default: rd_data_o = '0;
    endcase
  end

  assign take_o   = take_q;
  assign halt_o   = halt_q;
  assign new_st_o = nst_q;
  assign vec_o    = XLEN'({pfx_q, ofs_q, 4'b0000});

  // R3
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q);
  // R4
  no_take_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> !take_q);
  // R6
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (new_st_o & CLR_MASK) == '0);
  // R9
  save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_d |=> sv0_q == $past(pc_i));
  // R8
  syn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_syn |=> (syn_q & $past(syn_q)) == $past(syn_q));
  // R11
  wdog_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_stop_i |=> halt_q);
endmodule

// File: tb/test_mchk_ctrl.sv
module test_mchk_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] src_i = 0;
  logic mcp_n_i = 1, ext_en_i = 0, par_err_i = 0, wdog_stop_i = 0;
  logic dbg_unit_en_i = 1, dbg_clr_i = 0;
  logic [31:0] par_addr_i = 0, cur_st_i = 32'h0000_0020, pc_i = 0;
  logic wr_en_i = 0;
  logic [2:0] wr_sel_i = 0, rd_sel_i = 0;
  logic [31:0] wr_data_i = 0, rd_data_o, vec_o, new_st_o;
  logic take_o, halt_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mchk_ctrl i_mchk_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [2:0] sel, logic [31:0] exp);
    rd_sel_i = sel;
    #1 chk(req, rd_data_o, exp);
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 halt", {31'b0, halt_o}, 0);
    chk("R1 take", {31'b0, take_o}, 0);
    for (int s = 0; s < 6; s++) rd("R1 reg", 3'(s), 0);
  endtask

  task automatic t_regs();
    wr(3'd4, 32'hFFFF_ABCD);
    wr(3'd5, 32'hFFFF_F123);
    wr(3'd3, 32'h0000_1111);
    rd("R12 prefix", 3'd4, 32'h0000_ABCD);
    rd("R12 offset", 3'd5, 32'h0000_0123);
    rd("R12 daddr", 3'd3, 32'h0000_1111);
  endtask

  task automatic fire(logic [31:0] st, logic [31:0] pc, logic [7:0] s);
    @(negedge clk);
    cur_st_i = st; pc_i = pc; src_i = s;
    @(negedge clk);
    src_i = 0; cur_st_i = 32'h0000_0020;
  endtask

  task automatic t_take();
    fire(32'hFFFF_FFFF, 32'h1000_0040, 8'h04);
    chk("R2 take", {31'b0, take_o}, 1);
    chk("R2 vec", vec_o, 32'hABCD_1230);
    chk("R6 newst", new_st_o, 32'hFFFF_C010);
    rd("R9 save0", 3'd1, 32'h1000_0040);
    rd("R9 save1", 3'd2, 32'hFFFF_FFFF);
    rd("R8 syn", 3'd0, 32'h0000_0004);
    rd("R10 daddr kept", 3'd3, 32'h0000_1111);
    @(negedge clk);
    chk("R2 pulse", {31'b0, take_o}, 0);
  endtask

  task automatic t_dbg();
    dbg_unit_en_i = 0;
    fire(32'h0000_0030, 32'h2, 8'h01);
    chk("R7 dbg off", new_st_o, 32'h0);
    dbg_unit_en_i = 1; dbg_clr_i = 1;
    fire(32'h0001_0030, 32'h3, 8'h01);
    chk("R7 clr cfg", new_st_o, 32'h0001_0000);
    dbg_clr_i = 0;
  endtask

  task automatic t_syn();
    wr(3'd0, 32'h0000_03FF);
    rd("R8 w1c", 3'd0, 0);
    @(negedge clk);
    src_i = 8'h02; wr_en_i = 1; wr_sel_i = 3'd0; wr_data_i = 32'h2;
    @(negedge clk);
    src_i = 0; wr_en_i = 0;
    rd("R8 set wins", 3'd0, 32'h0000_0002);
    wr(3'd0, 32'h2);
  endtask

  task automatic t_ext();
    @(negedge clk);
    mcp_n_i = 0; ext_en_i = 0;
    @(negedge clk);
    chk("R5 masked take", {31'b0, take_o}, 0);
    rd("R5 masked syn", 3'd0, 0);
    ext_en_i = 1;
    @(negedge clk);
    mcp_n_i = 1; ext_en_i = 0;
    chk("R5 ext take", {31'b0, take_o}, 1);
    rd("R5 ext syn", 3'd0, 32'h0000_0100);
    wr(3'd0, 32'h100);
  endtask

  task automatic t_par();
    @(negedge clk);
    par_err_i = 1; par_addr_i = 32'hDEAD_BEE0;
    @(negedge clk);
    par_err_i = 0;
    chk("R10 take", {31'b0, take_o}, 1);
    rd("R10 daddr", 3'd3, 32'hDEAD_BEE0);
    rd("R10 syn", 3'd0, 32'h0000_0200);
    wr(3'd0, 32'h200);
  endtask

  task automatic t_stop();
    fire(32'h0000_0000, 32'h4, 8'h80);
    chk("R3 halt", {31'b0, halt_o}, 1);
    chk("R3 no take", {31'b0, take_o}, 0);
    rd("R3 syn", 3'd0, 32'h0000_0080);
    fire(32'hFFFF_FFFF, 32'h5, 8'h01);
    chk("R4 no take", {31'b0, take_o}, 0);
    rd("R4 syn kept", 3'd0, 32'h0000_0080);
    rd("R4 save0 kept", 3'd1, 32'h3);
    repeat (5) @(negedge clk);
    chk("R3 still halt", {31'b0, halt_o}, 1);
    do_reset();
    chk("R3 reset", {31'b0, halt_o}, 0);
  endtask

  task automatic t_wdog();
    @(negedge clk);
    wdog_stop_i = 1;
    @(negedge clk);
    wdog_stop_i = 0;
    chk("R11 halt", {31'b0, halt_o}, 1);
    chk("R11 no take", {31'b0, take_o}, 0);
    do_reset();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_regs(); t_take(); t_dbg(); t_syn();
        t_ext(); t_par(); t_stop(); t_wdog();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule